// File: doc/BRIEF.md
# Interface ID to Unit Translator

This block carries out the three translate operations that turn a globally unique interface identifier into a local logical unit number. A request presents an rs1 word, an rs2 data word, the current privilege level and a two-bit variant code. The rs1 word packs a device sequence number in its low twelve bits and the interface identifier above them. The block compares the request against a small associative table that boot code loads through a write port. It returns a packed word: the unit number sits in the low twelve bits and the low part of rs2 fills the rest.

A miss does not raise a flag. It returns one of three reserved unit numbers, and the variant that was issued chooses which one. Unit 0 makes later delegated commands trap. Unit 1 makes them return zero. Unit 2 makes them return minus one. A device number of zero is how software asks for the default implementation, and a table entry with device number zero serves that request. A translation never changes the table, and it never starts any device.

Top module: `unit_xlate`

## Requirements
- R1: `req_rs1[11:0]` is the device sequence number and `req_rs1[XLEN-1:12]` is the interface identifier; a request that matches an entry's identifier but not its device number misses.
- R2: A hit needs all four of these: the entry's valid bit is set, the identifier matches, the device number matches, and the entry's privilege mask shares a set bit with the one-hot `cur_priv` (user 4'b0001, supervisor 4'b0010, hypervisor 4'b0100, machine 4'b1000).
- R3: On a hit, `rsp_word[11:0]` is the entry's unit number and `rsp_word[XLEN-1:12]` is `req_rs2[XLEN-13:0]`; the top 12 bits of rs2 are dropped.
- R4: On a miss, `rsp_word` equals 0 for `req_kind` 2'd0 (trap), 1 for 2'd1 (return-zero) and 2 for 2'd2 (return-minus-one); code 2'd3 is reserved and behaves as 2'd0; bits 12 and up are zero.
- R5: When several entries match, the entry with the lowest index supplies the unit number.
- R6: `rsp_valid` is `req_valid` delayed by one clock, and `rsp_word` holds its value through cycles with no request.
- R7: Reset clears every entry's valid bit, `rsp_valid` and `rsp_word`, so every lookup misses until the table is written.
- R8: A write with `wr_en` high stores `wr_valid`, `wr_id`, `wr_dev`, `wr_mask` and `wr_unit` at index `wr_idx`; a lookup in the same cycle still sees the old entry, and the new one applies from the next cycle. Writing `wr_valid` low removes the entry.
- R9: A lookup leaves the table unchanged, so repeating the same request gives the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(ENTRIES) | Table index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_id | input | XLEN-12 | Interface identifier for the entry |
| wr_dev | input | 12 | Device sequence number for the entry |
| wr_mask | input | 4 | Privilege levels the entry serves |
| wr_unit | input | 12 | Unit number the entry returns |
| req_valid | input | 1 | Translation request strobe |
| req_kind | input | 2 | Variant: 0 trap, 1 return-zero, 2 return-minus-one, 3 reserved |
| req_rs1 | input | XLEN | Identifier and device number |
| req_rs2 | input | XLEN | Data word to pack |
| cur_priv | input | 4 | Current privilege, one-hot |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_word | output | XLEN | Packed unit number and data |

## Verification
The bench builds the block with its defaults: XLEN of 32 and 16 entries. With these values the 20-bit identifier fills rs1 above the device field exactly, and the dropped top twelve bits of rs2 appear as a visible truncation in the result. With 16 entries the last index, 15, can be loaded and hit. Overlapping entries with shared identifiers and different privilege masks make lowest-index priority visible. A write in the same cycle as a lookup shows the old-versus-new ordering.

// File: rtl/unit_xlate_pkg.sv
package unit_xlate_pkg;

    localparam int UNIT_W = 12;
    localparam int DEV_W  = 12;
    localparam int PRIV_W = 4;

    typedef logic [UNIT_W-1:0] unit_t;
    typedef logic [DEV_W-1:0]  dev_t;
    typedef logic [PRIV_W-1:0] priv_t;

    localparam priv_t PRIV_USER  = 4'b0001;
    localparam priv_t PRIV_SUPER = 4'b0010;
    localparam priv_t PRIV_HYPER = 4'b0100;
    localparam priv_t PRIV_MACH  = 4'b1000;

    typedef enum logic [1:0] {
        XK_TRAP  = 2'd0,
        XK_ZERO  = 2'd1,
        XK_MINUS = 2'd2,
        XK_RSVD  = 2'd3
    } xkind_e;

    localparam unit_t UNIT_TRAP  = 12'd0;
    localparam unit_t UNIT_ZERO  = 12'd1;
    localparam unit_t UNIT_MINUS = 12'd2;

    // Per-entry attributes; the identifier is kept apart since its width follows XLEN.
    typedef struct packed {
        logic  valid;
        dev_t  dev;
        priv_t mask;
        unit_t unit;
    } entry_attr_t;

    function automatic unit_t fallback_unit(input logic [1:0] kind);
        case (kind)
            XK_ZERO:  return UNIT_ZERO;
            XK_MINUS: return UNIT_MINUS;
            default:  return UNIT_TRAP;
        endcase
    endfunction

endpackage

// File: rtl/unit_xlate_table.sv
module unit_xlate_table
    import unit_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ID_W    = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_attr_t       wr_attr,
    input  logic [ID_W-1:0]   wr_id,
    output entry_attr_t       attr_q [ENTRIES],
    output logic [ID_W-1:0]   id_q   [ENTRIES]
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                attr_q[e].valid <= 1'b0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                attr_q[e].valid <= wr_attr.valid;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == IDX_W'(e)) begin
                attr_q[e].dev  <= wr_attr.dev;
                attr_q[e].mask <= wr_attr.mask;
                attr_q[e].unit <= wr_attr.unit;
                id_q[e]        <= wr_id;
            end
        end
    end

endmodule

// File: rtl/unit_xlate_match.sv
module unit_xlate_match
    import unit_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int ID_W    = 20
) (
    input  entry_attr_t       attr_q [ENTRIES],
    input  logic [ID_W-1:0]   id_q   [ENTRIES],
    input  logic [ID_W-1:0]   key_id,
    input  dev_t              key_dev,
    input  priv_t             key_priv,
    output logic [ENTRIES-1:0] hit_vec
);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign hit_vec[e] = attr_q[e].valid
                          && (id_q[e] == key_id)
                          && (attr_q[e].dev == key_dev)
                          && ((attr_q[e].mask & key_priv) != '0);
    end

endmodule

// File: rtl/unit_xlate_prio.sv
module unit_xlate_prio
    import unit_xlate_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES-1:0] hit_vec,
    input  entry_attr_t        attr_q [ENTRIES],
    output logic               any_hit,
    output unit_t              sel_unit
);

    // Scan from the top down so the lowest matching index is written last.
    always_comb begin
        any_hit  = 1'b0;
        sel_unit = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                any_hit  = 1'b1;
                sel_unit = attr_q[e].unit;
            end
        end
    end

endmodule

// File: rtl/unit_xlate.sv
module unit_xlate
    import unit_xlate_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ENTRIES = 16,
    localparam int ID_W   = XLEN - DEV_W,
    localparam int DATA_W = XLEN - UNIT_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [11:0]       wr_dev,
    input  logic [3:0]        wr_mask,
    input  logic [11:0]       wr_unit,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [XLEN-1:0]   req_rs1,
    input  logic [XLEN-1:0]   req_rs2,
    input  logic [3:0]        cur_priv,
    output logic              rsp_valid,
    output logic [XLEN-1:0]   rsp_word
);

    entry_attr_t        wr_attr;
    entry_attr_t        attr_q [ENTRIES];
    logic [ID_W-1:0]    id_q   [ENTRIES];
    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    unit_t              sel_unit;
    logic [XLEN-1:0]    next_word;

    assign wr_attr = '{valid: wr_valid, dev: wr_dev, mask: wr_mask, unit: wr_unit};

    unit_xlate_table #(.ENTRIES(ENTRIES), .ID_W(ID_W)) table_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_attr (wr_attr),
        .wr_id   (wr_id),
        .attr_q  (attr_q),
        .id_q    (id_q)
    );

    unit_xlate_match #(.ENTRIES(ENTRIES), .ID_W(ID_W)) match_i (
        .attr_q   (attr_q),
        .id_q     (id_q),
        .key_id   (req_rs1[XLEN-1:DEV_W]),
        .key_dev  (req_rs1[DEV_W-1:0]),
        .key_priv (cur_priv),
        .hit_vec  (hit_vec)
    );

    unit_xlate_prio #(.ENTRIES(ENTRIES)) prio_i (
        .hit_vec  (hit_vec),
        .attr_q   (attr_q),
        .any_hit  (any_hit),
        .sel_unit (sel_unit)
    );

    always_comb begin
        if (any_hit) begin
            next_word = {req_rs2[DATA_W-1:0], sel_unit};
        end else begin
            next_word = {{DATA_W{1'b0}}, fallback_unit(req_kind)};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_word  <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_word <= next_word;
            end
        end
    end

endmodule

// File: rtl/unit_xlate_chk.sv
module unit_xlate_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic            req_valid,
    input logic [XLEN-1:0] req_rs2,
    input logic            rsp_valid,
    input logic [XLEN-1:0] rsp_word
);

    logic written_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            written_q <= 1'b0;
        end else if (wr_en) begin
            written_q <= 1'b1;
        end
    end

    // R6: response strobe follows the request by one clock
    p_rsp_follows_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_idle_r6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_word_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> $stable(rsp_word));

    // R3: a unit above the fallbacks can only come from a hit, which carries rs2
    p_hit_data_r3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_word[11:0] > 12'd2)
            |-> rsp_word[XLEN-1:12] == $past(req_rs2[XLEN-13:0]));

    // R7: before any table write every lookup returns a fallback code
    p_empty_miss_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !written_q)
            |-> (rsp_word[XLEN-1:12] == '0 && rsp_word[11:0] <= 12'd2));

endmodule

bind unit_xlate unit_xlate_chk #(.XLEN(XLEN)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .req_valid (req_valid),
    .req_rs2   (req_rs2),
    .rsp_valid (rsp_valid),
    .rsp_word  (rsp_word)
);

// File: tb/unit_xlate_tb_top.sv
module unit_xlate_tb_top;

    localparam int XLEN    = 32;
    localparam int ENTRIES = 16;
    localparam int IDX_W   = $clog2(ENTRIES);
    localparam int ID_W    = XLEN - 12;

    localparam logic [3:0] PU = 4'b0001;
    localparam logic [3:0] PS = 4'b0010;
    localparam logic [3:0] PH = 4'b0100;
    localparam logic [3:0] PM = 4'b1000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic              wr_valid = 1'b0;
    logic [ID_W-1:0]   wr_id = '0;
    logic [11:0]       wr_dev = '0;
    logic [3:0]        wr_mask = '0;
    logic [11:0]       wr_unit = '0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [XLEN-1:0]   req_rs1 = '0;
    logic [XLEN-1:0]   req_rs2 = '0;
    logic [3:0]        cur_priv = 4'b0001;
    logic              rsp_valid;
    logic [XLEN-1:0]   rsp_word;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    unit_xlate #(.XLEN(XLEN), .ENTRIES(ENTRIES)) dut_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_id(wr_id),
        .wr_dev(wr_dev), .wr_mask(wr_mask), .wr_unit(wr_unit),
        .req_valid(req_valid), .req_kind(req_kind), .req_rs1(req_rs1),
        .req_rs2(req_rs2), .cur_priv(cur_priv),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word)
    );

    task automatic check(input string tag, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_entry(input int idx, input logic v, input logic [ID_W-1:0] id,
                               input logic [11:0] dev, input logic [3:0] mask, input logic [11:0] unit);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = v;
        wr_id = id; wr_dev = dev; wr_mask = mask; wr_unit = unit;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup(input string tag, input logic [1:0] kind, input logic [ID_W-1:0] id,
                          input logic [11:0] dev, input logic [3:0] priv,
                          input logic [XLEN-1:0] rs2, input logic [XLEN-1:0] exp);
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_rs1 = {id, dev}; req_rs2 = rs2; cur_priv = priv;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, XLEN'(rsp_valid), XLEN'(1));
        check(tag, rsp_word, exp);
    endtask

    task automatic t_reset;
        check("R7 reset rsp_valid", XLEN'(rsp_valid), '0);
        check("R7 reset rsp_word", rsp_word, '0);
        lookup("R7 empty table miss", 2'd1, 20'hABCDE, 12'd0, PU, 32'hFFFF_FFFF, 32'd1);
    endtask

    task automatic t_load;
        write_entry(0,  1'b1, 20'hABCDE, 12'd0, PU,            12'd32);
        write_entry(1,  1'b1, 20'hABCDE, 12'd1, PS | PH | PM,  12'd33);
        write_entry(2,  1'b1, 20'hABCDE, 12'd0, PS | PH | PM,  12'd34);
        write_entry(3,  1'b1, 20'h12345, 12'd0, PU | PS | PH,  12'd40);
        write_entry(5,  1'b1, 20'h12345, 12'd0, PS,            12'd41);
        write_entry(9,  1'b1, 20'h12345, 12'd0, PM,            12'd42);
        write_entry(15, 1'b1, 20'hD0B0D, 12'd7, 4'b1111,       12'h7FF);
    endtask

    task automatic t_match;
        lookup("R2 user default", 2'd0, 20'hABCDE, 12'd0, PU, 32'h0, 32'h0000_0020);
        lookup("R2 super default", 2'd0, 20'hABCDE, 12'd0, PS, 32'h0, 32'h0000_0022);
        lookup("R1 device one super", 2'd0, 20'hABCDE, 12'd1, PS, 32'h0, 32'h0000_0021);
        lookup("R2 priv mask miss", 2'd2, 20'hABCDE, 12'd1, PU, 32'h0, 32'd2);
        lookup("R1 device mismatch", 2'd1, 20'hABCDE, 12'd2, PH, 32'h0, 32'd1);
        lookup("R8 last index", 2'd0, 20'hD0B0D, 12'd7, PH, 32'h0, 32'h0000_07FF);
    endtask

    task automatic t_data;
        lookup("R3 rs2 packing", 2'd0, 20'hABCDE, 12'd0, PU, 32'hFFF1_2345, 32'h1234_5020);
        lookup("R3 top rs2 dropped", 2'd0, 20'hABCDE, 12'd0, PM, 32'hABC0_0001, 32'h0000_1022);
    endtask

    task automatic t_miss;
        lookup("R4 trap variant",  2'd0, 20'h55555, 12'd0, PU, 32'hFFFF_FFFF, 32'd0);
        lookup("R4 zero variant",  2'd1, 20'h55555, 12'd0, PU, 32'hFFFF_FFFF, 32'd1);
        lookup("R4 minus variant", 2'd2, 20'h55555, 12'd0, PU, 32'hFFFF_FFFF, 32'd2);
        lookup("R4 reserved code", 2'd3, 20'h55555, 12'd0, PU, 32'hFFFF_FFFF, 32'd0);
    endtask

    task automatic t_prio;
        lookup("R5 overlap super", 2'd0, 20'h12345, 12'd0, PS, 32'h0, 32'h0000_0028);
        lookup("R5 machine only", 2'd0, 20'h12345, 12'd0, PM, 32'h0, 32'h0000_002A);
    endtask

    task automatic t_hold;
        logic [XLEN-1:0] held;
        lookup("R6 before idle", 2'd0, 20'h12345, 12'd0, PU, 32'h0000_0003, 32'h0000_3028);
        held = rsp_word;
        @(negedge clk);
        req_rs2 = 32'hDEAD_BEEF;
        @(negedge clk);
        check("R6 idle valid low", XLEN'(rsp_valid), '0);
        check("R6 idle word held", rsp_word, held);
    endtask

    task automatic t_write_order;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = '0; wr_valid = 1'b0;
        wr_id = 20'hABCDE; wr_dev = 12'd0; wr_mask = PU; wr_unit = 12'd32;
        req_valid = 1'b1; req_kind = 2'd0; req_rs1 = {20'hABCDE, 12'd0};
        req_rs2 = 32'h0; cur_priv = PU;
        @(negedge clk);
        wr_en = 1'b0; req_valid = 1'b0;
        check("R8 same cycle sees old", rsp_word, 32'h0000_0020);
        lookup("R8 removed entry", 2'd0, 20'hABCDE, 12'd0, PU, 32'h0, 32'd0);
        write_entry(0, 1'b1, 20'hABCDE, 12'd0, PU, 12'd50);
        lookup("R8 rewritten entry", 2'd0, 20'hABCDE, 12'd0, PU, 32'h0, 32'h0000_0032);
    endtask

    task automatic t_repeat;
        lookup("R9 repeat one", 2'd0, 20'hD0B0D, 12'd7, PU, 32'h1, 32'h0000_17FF);
        lookup("R9 repeat two", 2'd0, 20'hD0B0D, 12'd7, PU, 32'h1, 32'h0000_17FF);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load();
        t_match();
        t_data();
        t_miss();
        t_prio();
        t_hold();
        t_write_order();
        t_repeat();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule